// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the moment at which something happens on an external capture line. Two free-running 16-bit timers are routed in from elsewhere in the chip. When a qualified event appears on the capture line, the block copies the value of one of those timers into a 16-bit capture register. The event can be a falling edge, a rising edge, or every fourth or sixteenth rising edge. The capture register is read as a low byte and a high byte over a small register port. Each capture raises an interrupt request flag, and that flag stays high until software clears it.

The capture line is asynchronous. It passes through a synchronizer chain and then an edge detector, so a level change on the line is captured on the third rising clock edge after it is sampled. A prescaler counts qualified rising edges for the divide-by-4 and divide-by-16 modes. Every write to the control register restarts that count. A new capture overwrites the register whether or not software has read the previous value.

Top module: `tcap_unit`

## Requirements
- R1: The 16-bit capture register is read as its low byte at address 1 and its high byte at address 2. It changes only when a capture event occurs.
- R2: When the capture line changes just after clock edge N and the change qualifies, the capture register loads on edge N+3. The value loaded is the one the selected timer holds between edges N+2 and N+3.
- R3: Mode field value 4'b0100 captures on every falling edge of the capture line. Value 4'b0101 captures on every rising edge.
- R4: Mode 4'b0110 captures on every 4th rising edge and mode 4'b0111 on every 16th rising edge, counting from the last control write.
- R5: Any other mode value disables capture. The capture register keeps its value and the flag is not set.
- R6: The control register is at address 0. Bits [3:0] hold the mode and bit 4 is the timer select (0 = timer A, 1 = timer B). It reads back in the same bit positions with all other bits zero.
- R7: Every capture sets the interrupt flag. The flag drives `irq` and reads as bit 0 at address 3. It stays set until a write to address 3 with data bit 0 = 1.
- R8: A flag-clear write on the same clock edge as a capture leaves the flag set.
- R9: A second capture before any read overwrites the first value.
- R10: A write to the control register clears the prescaler's partial count.
- R11: After reset all four registers read zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_in | input | 1 | Asynchronous capture line |
| tmr_a | input | 16 | Timer A count |
| tmr_b | input | 16 | Timer B count |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Capture interrupt request flag |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, 8-bit bytes, and prescale divisors of 4 and 16. With these values the divide-by-16 wrap is reached in sixteen pulses. The bench drives the timers from its own cycle counter, with timer B as the bitwise inverse of timer A. A captured value therefore identifies both the exact cycle and the source timer, so a latency error or a wrong timer select shows up directly in the captured value.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_CAPL = 2'd1;
  localparam logic [1:0] ADR_CAPH = 2'd2;
  localparam logic [1:0] ADR_STAT = 2'd3;

  typedef enum logic [2:0] {
    EV_OFF,
    EV_FALL,
    EV_RISE,
    EV_RISE4,
    EV_RISE16
  } ev_kind_e;

  function automatic ev_kind_e decode_mode(input logic [3:0] m);
    case (m)
      4'b0100: return EV_FALL;
      4'b0101: return EV_RISE;
      4'b0110: return EV_RISE4;
      4'b0111: return EV_RISE16;
      default: return EV_OFF;
    endcase
  endfunction

  function automatic logic is_prescaled(input ev_kind_e k);
    return (k == EV_RISE4) || (k == EV_RISE16);
  endfunction

endpackage

// File: rtl/tcap_sync_edge.sv
module tcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/tcap_prescale.sv
module tcap_prescale
  import tcap_pkg::*;
#(
  parameter int DIV_MID = 4,
  parameter int DIV_HI  = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clr,
  input  logic     rise,
  input  ev_kind_e kind,
  output logic     fire
);
  localparam int CW = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          at_last;

  assign last    = (kind == EV_RISE16) ? CW'(DIV_HI - 1) : CW'(DIV_MID - 1);
  assign at_last = (cnt == last);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                           cnt <= '0;
    else if (clr)                         cnt <= '0;
    else if (rise && is_prescaled(kind))  cnt <= at_last ? '0 : cnt + 1'b1;

  always_comb begin
    fire = 1'b0;
    if (rise) begin
      if (kind == EV_RISE)           fire = 1'b1;
      else if (is_prescaled(kind))   fire = at_last;
    end
  end
endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
  import tcap_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int STAGES  = 2,
  parameter int DIV_MID = 4,
  parameter int DIV_HI  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_in,
  input  logic [2*BYTE_W-1:0] tmr_a,
  input  logic [2*BYTE_W-1:0] tmr_b,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  output logic [BYTE_W-1:0]   reg_rdata,
  output logic                irq
);
  localparam int TW = 2 * BYTE_W;

  logic [3:0]    mode_q;
  logic          tsel_q;
  logic [TW-1:0] cap_q;
  logic          flag_q;

  logic          edge_rise, edge_fall, ps_fire, cap_event;
  logic          ctrl_wr, clr_req;
  logic [TW-1:0] tmr_pick;
  ev_kind_e      kind;

  wire unused_wbits = ^reg_wdata[BYTE_W-1:5];

  assign kind     = decode_mode(mode_q);
  assign ctrl_wr  = reg_wr && (reg_addr == ADR_CTRL);
  assign clr_req  = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[0];
  assign tmr_pick = tsel_q ? tmr_b : tmr_a;

  tcap_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in),
    .rise(edge_rise), .fall(edge_fall)
  );

  tcap_prescale #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_ps (
    .clk(clk), .rst_n(rst_n), .clr(ctrl_wr),
    .rise(edge_rise), .kind(kind), .fire(ps_fire)
  );

  assign cap_event = ps_fire || ((kind == EV_FALL) && edge_fall);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= '0;
      tsel_q <= 1'b0;
    end else if (ctrl_wr) begin
      mode_q <= reg_wdata[3:0];
      tsel_q <= reg_wdata[4];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cap_q <= '0;
    else if (cap_event) cap_q <= tmr_pick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         flag_q <= 1'b0;
    else if (cap_event) flag_q <= 1'b1;
    else if (clr_req)   flag_q <= 1'b0;

  assign irq = flag_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_CTRL: reg_rdata[4:0] = {tsel_q, mode_q};
      ADR_CAPL: reg_rdata      = cap_q[BYTE_W-1:0];
      ADR_CAPH: reg_rdata      = cap_q[TW-1:BYTE_W];
      default:  reg_rdata[0]   = flag_q;
    endcase
  end
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_rise,
  input logic          edge_fall,
  input logic          cap_event,
  input logic          clr_req,
  input logic          tsel_q,
  input logic [3:0]    mode_q,
  input logic [TW-1:0] tmr_a,
  input logic [TW-1:0] tmr_b,
  input logic [TW-1:0] cap_q,
  input logic          irq
);
  logic mode_off;
  assign mode_off = !(mode_q inside {4'b0100, 4'b0101, 4'b0110, 4'b0111});

  AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_rise && edge_fall));                                        // R2
  AST_CAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> cap_q == ($past(tsel_q) ? $past(tmr_b) : $past(tmr_a))); // R6
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_event |=> $stable(cap_q));                                    // R1
  AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    mode_off |-> !cap_event);                                          // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_event |=> irq);                                                // R7
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !cap_event) |=> !irq);                                 // R7
  AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_req) |=> irq);                                        // R7
  AST_CLR_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_event && clr_req) |=> irq);                                   // R8
  AST_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_event && edge_fall) |-> (mode_q == 4'b0100));                 // R3
endmodule

bind tcap_unit tcap_chk #(.TW(2*BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_rise(edge_rise), .edge_fall(edge_fall),
  .cap_event(cap_event), .clr_req(clr_req), .tsel_q(tsel_q), .mode_q(mode_q),
  .tmr_a(tmr_a), .tmr_b(tmr_b), .cap_q(cap_q), .irq(irq)
);

// File: tb/sim_tcap_unit.sv
module sim_tcap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_in = 1'b0;
  logic [15:0] tmr_a, tmr_b;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        irq;

  logic [31:0] cyc = 0;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  logic [15:0] exp_cap = 16'h0;
  logic        exp_hit;
  int          rcnt;
  logic [3:0]  cur_mode;
  logic        cur_tsel;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign tmr_a = cyc[15:0];
  assign tmr_b = ~cyc[15:0];

  tcap_unit u0 (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // {mode[3:0], tsel in a nibble, pulse count}
  localparam logic [15:0] VEC [10] = '{
    {4'b0101, 4'h0, 8'd1},   // R3 rising
    {4'b0101, 4'h1, 8'd2},   // R9 overwrite, timer B
    {4'b0100, 4'h0, 8'd2},   // R3 falling
    {4'b0110, 4'h0, 8'd3},   // R4 short of 4
    {4'b0110, 4'h1, 8'd4},   // R4 4th edge
    {4'b0111, 4'h0, 8'd15},  // R4 short of 16
    {4'b0111, 4'h1, 8'd16},  // R4 16th edge
    {4'b0000, 4'h0, 8'd2},   // R5 disabled
    {4'b1101, 4'h1, 8'd1},   // R5 near-match disabled
    {4'b0110, 4'h0, 8'd9}    // R4 two wraps, R9
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic int div_of(input logic [3:0] m);
    case (m)
      4'b0101: return 1;
      4'b0110: return 4;
      4'b0111: return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] stamp(input logic [31:0] c0, input logic sel);
    logic [15:0] v;
    v = c0[15:0] + 16'd2;   // R2: third edge samples the timer two cycles on
    return sel ? ~v : v;
  endfunction

  task automatic set_mode(input logic [3:0] m, input logic s);
    wr(2'd0, {3'b000, s, m});
    cur_mode = m; cur_tsel = s; rcnt = 0;
  endtask

  task automatic pulse();
    @(negedge clk);
    cap_in = 1'b1;
    rcnt++;
    if (div_of(cur_mode) != 0 && (rcnt % div_of(cur_mode)) == 0) begin
      exp_cap = stamp(cyc, cur_tsel); exp_hit = 1'b1;
    end
    repeat (4) @(negedge clk);
    cap_in = 1'b0;
    if (cur_mode == 4'b0100) begin
      exp_cap = stamp(cyc, cur_tsel); exp_hit = 1'b1;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_state(input string req);
    logic [7:0] lo, hi, st;
    rd(2'd1, lo); rd(2'd2, hi); rd(2'd3, st);
    chk({req, " capture"}, {hi, lo}, exp_cap);
    chk({req, " flag"}, {15'd0, st[0]}, {15'd0, exp_hit});
    chk({req, " irq"}, {15'd0, irq}, {15'd0, exp_hit});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R11 reset reg", {8'd0, d}, 16'd0);
    end
    chk("R11 reset irq", {15'd0, irq}, 16'd0);

    // R6 control readback
    wr(2'd0, 8'hF7);
    rd(2'd0, d);
    chk("R6 ctrl readback", {8'd0, d}, 16'h0017);

    // Vector table walk
    for (int i = 0; i < 10; i++) begin
      set_mode(VEC[i][15:12], VEC[i][8]);
      wr(2'd3, 8'h01);
      exp_hit = 1'b0;
      for (int p = 0; p < int'(VEC[i][7:0]); p++) pulse();
      check_state($sformatf("R1/R3/R4/R5/R9 vec%0d", i));
    end

    // R10 control write clears the partial count
    set_mode(4'b0110, 1'b0);
    wr(2'd3, 8'h01);
    exp_hit = 1'b0;
    pulse(); pulse();
    set_mode(4'b0110, 1'b0);
    pulse(); pulse();
    check_state("R10 after restart 2 edges");
    pulse(); pulse();
    check_state("R10 after restart 4 edges");

    // R7 clear write drops flag
    wr(2'd3, 8'h01);
    exp_hit = 1'b0;
    check_state("R7 cleared");
    // R7 write with bit0 = 0 leaves flag
    set_mode(4'b0101, 1'b1);
    pulse();
    wr(2'd3, 8'h00);
    check_state("R7 no-clear write");

    // R8 clear on the capture edge: capture wins
    set_mode(4'b0101, 1'b0);
    wr(2'd3, 8'h01);
    @(negedge clk);
    cap_in = 1'b1;
    exp_cap = stamp(cyc, 1'b0);
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h01;
    @(negedge clk);
    reg_wr = 1'b0;
    exp_hit = 1'b1;
    check_state("R8 priority");
    cap_in = 1'b0;
    repeat (4) @(negedge clk);

    // R2 latency: nothing captured two edges after the change
    wr(2'd3, 8'h01);
    @(negedge clk);
    cap_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1 chk("R2 not yet captured", {15'd0, irq}, 16'd0);
    @(negedge clk);
    #1 chk("R2 captured on third edge", {15'd0, irq}, 16'd1);
    cap_in = 1'b0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule